// File: doc/BRIEF.md
# Hash Input Block Aligner

This block sits between a host byte stream and an MD5/SHA-1 compression engine. The host issues requests, each of them an update or a final, together with a byte length, and then streams that many bytes. The block turns the stream into 32-bit words for the engine. On an update it forwards only whole 64-byte blocks and keeps any leftover bytes in an internal buffer. That way the engine never has to hold a partial block between two requests.

On a final request the block forwards every complete word and hands the last 0 to 3 bytes to a padding stage. It hands over the total message byte count with them, and then clears its context for the next message. Word delivery is paced by a credit that comes from the engine's free-space report. The running byte count and the retained bytes can be read out as a context and restored later, so that independent messages can be interleaved on one engine.

Top module: `hash_block_aligner`

## Requirements
- R1: An update whose retained plus new byte total is below 64 produces no output word; the new bytes are appended after the retained ones, and `ctx_count` grows by the request length.
- R2: An update forwards exactly the largest multiple of 64 that fits in (retained + new) bytes. The remaining 0 to 63 bytes are retained, and the processed count grows by the number of forwarded bytes.
- R3: A final forwards the largest multiple of 4 of (retained + new) bytes. In the cycle the request completes, it raises `tail_valid` for one cycle with the leftover byte count on `tail_nbytes` (0 to 3) and those bytes in the low lanes of `tail_data`, oldest in bits 7:0 and unused lanes zero. `tail_total` carries the total message byte count. The processed count and the retained length then become zero.
- R4: Output words carry retained bytes first, then request bytes, in arrival order. Each word is packed little-endian: its oldest byte is in bits 7:0 and its newest in bits 31:24.
- R5: An update of length zero does nothing: `busy` stays low, no word is sent and the context is unchanged.
- R6: A request whose length plus the retained length exceeds 2^LEN_W-1 raises `cmd_err` in its accept cycle and changes nothing.
- R7: After a request starts, at most CREDIT_INIT (32) words are sent. Once the credit is spent, `out_valid` stays low while `fifo_space` is zero. The credit is then reloaded from `fifo_space` each cycle that it is zero.
- R8: `ctx_count` equals processed bytes plus retained bytes. Byte i of `ctx_buf` (bits 8i+7:8i) is the i-th oldest retained byte.
- R9: While idle, `rs_valid` loads a processed count equal to `rs_count` with its low 6 bits cleared, a retained length equal to those low 6 bits, and the retained bytes from `rs_buf`. A restore takes priority over a command, so `cmd_ready` is low while `rs_valid` is high.
- R10: `cmd_ready` is high only when the block is idle. `busy` rises after a request with work is accepted and falls the cycle after its last word or tail. While `out_valid` is high and not accepted, `out_valid` and `out_data` hold.
- R11: After reset the block is idle with an empty context: `busy`, `out_valid` and `tail_valid` are low, `ctx_count` is zero and `cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Request command valid |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| cmd_final | input | 1 | 1 = final request, 0 = update |
| cmd_len | input | LEN_W | Number of request bytes that follow |
| cmd_err | output | 1 | Request rejected for length overflow |
| in_valid | input | 1 | Request byte valid |
| in_ready | output | 1 | Request byte accepted |
| in_data | input | 8 | Request byte |
| out_valid | output | 1 | Word to engine valid |
| out_ready | input | 1 | Engine accepts word |
| out_data | output | 32 | Word to engine, little-endian packed |
| fifo_space | input | SPACE_W | Engine free-space report in words |
| tail_valid | output | 1 | One-cycle pulse to the padding stage |
| tail_data | output | 24 | Leftover bytes of a final |
| tail_nbytes | output | 2 | Number of leftover bytes |
| tail_total | output | CNT_W | Total message byte count |
| busy | output | 1 | A request is in progress |
| ctx_count | output | CNT_W | Saved context: processed plus retained bytes |
| ctx_buf | output | BLK_BYTES*8 | Saved context: retained bytes |
| rs_valid | input | 1 | Restore context (used while idle) |
| rs_count | input | CNT_W | Restored byte count |
| rs_buf | input | BLK_BYTES*8 | Restored retained bytes |

## Verification
The bench uses the default configuration: 64-byte blocks, a 32-bit length, a 64-bit counter, a 6-bit space field and 32 credits. It reduces the engine's free space to 7 words, so the credit is exhausted and reloaded many times within ordinary requests. Its sweep runs every retained length from 0 to 63 against a spread of update and final lengths, which reaches every tail size and every block-crossing split. Separate runs starve the space report to expose the 32-word limit, push a length that overflows the 32-bit field, and restore a context whose low bits leave five retained bytes.

// File: rtl/hba_pkg.sv
`timescale 1ns/1ps
package hba_pkg;
   typedef enum logic {
      HBA_UPDATE = 1'b0,
      HBA_FINAL  = 1'b1
   } hba_kind_e;

   localparam int unsigned HBA_WORD_BYTES = 4;
endpackage

// File: rtl/hba_quota.sv
`timescale 1ns/1ps
module hba_quota #(
   parameter int unsigned LEN_W  = 32,
   parameter int unsigned BLK_LG = 6,
   parameter int unsigned FILL_W = 7
) (
   input  logic [FILL_W-1:0] held,
   input  logic [LEN_W-1:0]  req_len,
   input  logic              final_req,
   output logic              ovf,
   output logic [LEN_W-1:0]  quota
);
   localparam logic [LEN_W-1:0] BLK_MASK  = ~LEN_W'((1 << BLK_LG) - 1);
   localparam logic [LEN_W-1:0] WORD_MASK = ~LEN_W'(hba_pkg::HBA_WORD_BYTES - 1);

   logic [LEN_W:0] sum;

   always_comb begin
      sum   = {1'b0, req_len} + (LEN_W+1)'(held);
      ovf   = sum[LEN_W];
      quota = final_req ? (sum[LEN_W-1:0] & WORD_MASK) : (sum[LEN_W-1:0] & BLK_MASK);
   end
endmodule

// File: rtl/hba_byte_buffer.sv
`timescale 1ns/1ps
module hba_byte_buffer #(
   parameter int unsigned DEPTH = 64,
   localparam int unsigned FILL_W = $clog2(DEPTH + 1),
   localparam int unsigned WIDTH  = DEPTH * 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              load,
   input  logic [FILL_W-1:0] load_fill,
   input  logic [WIDTH-1:0]  load_data,
   input  logic              push,
   input  logic [7:0]        push_byte,
   input  logic              pop,
   output logic [FILL_W-1:0] fill,
   output logic [WIDTH-1:0]  data
);
   localparam int unsigned WB = hba_pkg::HBA_WORD_BYTES;

   logic [WIDTH-1:0]  data_nxt;
   logic [FILL_W-1:0] wr_pos;
   logic [FILL_W-1:0] fill_nxt;

   always_comb begin
      data_nxt = pop ? (data >> (WB * 8)) : data;
      wr_pos   = pop ? (fill - FILL_W'(WB)) : fill;
      if (push) data_nxt[{wr_pos, 3'b000} +: 8] = push_byte;
      fill_nxt = wr_pos + FILL_W'(push);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data <= '0;
         fill <= '0;
      end else if (load) begin
         data <= load_data;
         fill <= load_fill;
      end else if (clr) begin
         data <= '0;
         fill <= '0;
      end else begin
         data <= data_nxt;
         fill <= fill_nxt;
      end
   end

   // R2
   push_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> fill < FILL_W'(DEPTH));
   // R4
   pop_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> fill >= FILL_W'(WB));
   // R2
   fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= FILL_W'(DEPTH));
endmodule

// File: rtl/hba_credit.sv
`timescale 1ns/1ps
module hba_credit #(
   parameter int unsigned SPACE_W = 6,
   parameter int unsigned INIT    = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               take,
   input  logic [SPACE_W-1:0] space,
   output logic               avail
);
   if (INIT == 0 || INIT >= (1 << SPACE_W)) begin : g_bad_init
      $error("hba_credit: INIT must be nonzero and fit in SPACE_W bits");
   end

   logic [SPACE_W-1:0] credit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                credit <= SPACE_W'(INIT);
      else if (start)            credit <= SPACE_W'(INIT);
      else if (take)             credit <= credit - 1'b1;
      else if (credit == '0)     credit <= space;
   end

   assign avail = (credit != '0);

   // R7
   credit_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> credit != '0);
   // R7
   credit_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (credit == '0 && !start) |=> credit == $past(space));
endmodule

// File: rtl/hash_block_aligner.sv
`timescale 1ns/1ps
module hash_block_aligner #(
   parameter int unsigned BLK_BYTES   = 64,
   parameter int unsigned LEN_W       = 32,
   parameter int unsigned CNT_W       = 64,
   parameter int unsigned SPACE_W     = 6,
   parameter int unsigned CREDIT_INIT = 32
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cmd_valid,
   output logic                   cmd_ready,
   input  logic                   cmd_final,
   input  logic [LEN_W-1:0]       cmd_len,
   output logic                   cmd_err,
   input  logic                   in_valid,
   output logic                   in_ready,
   input  logic [7:0]             in_data,
   output logic                   out_valid,
   input  logic                   out_ready,
   output logic [31:0]            out_data,
   input  logic [SPACE_W-1:0]     fifo_space,
   output logic                   tail_valid,
   output logic [23:0]            tail_data,
   output logic [1:0]             tail_nbytes,
   output logic [CNT_W-1:0]       tail_total,
   output logic                   busy,
   output logic [CNT_W-1:0]       ctx_count,
   output logic [BLK_BYTES*8-1:0] ctx_buf,
   input  logic                   rs_valid,
   input  logic [CNT_W-1:0]       rs_count,
   input  logic [BLK_BYTES*8-1:0] rs_buf
);
   import hba_pkg::*;

   localparam int unsigned BLK_LG = $clog2(BLK_BYTES);
   localparam int unsigned FILL_W = BLK_LG + 1;
   localparam int unsigned WB     = HBA_WORD_BYTES;

   if ((1 << BLK_LG) != BLK_BYTES || BLK_BYTES < 8) begin : g_bad_blk
      $error("hash_block_aligner: BLK_BYTES must be a power of two of at least 8");
   end
   if (LEN_W <= BLK_LG || CNT_W < LEN_W) begin : g_bad_width
      $error("hash_block_aligner: LEN_W must exceed BLK_LG and CNT_W must cover LEN_W");
   end

   logic [FILL_W-1:0]      fill;
   logic [BLK_BYTES*8-1:0] buf_data;
   logic [LEN_W-1:0]       rem_q, quota_q, quota_c;
   logic [CNT_W-1:0]       proc_cnt;
   hba_kind_e              kind_q;
   logic                   ovf, cmd_fire, start, push, pop, done, rs_fire, avail;

   hba_quota #(.LEN_W(LEN_W), .BLK_LG(BLK_LG), .FILL_W(FILL_W)) u_quota (
      .held(fill), .req_len(cmd_len), .final_req(cmd_final),
      .ovf(ovf), .quota(quota_c));

   hba_credit #(.SPACE_W(SPACE_W), .INIT(CREDIT_INIT)) u_credit (
      .clk(clk), .rst_n(rst_n), .start(start), .take(pop),
      .space(fifo_space), .avail(avail));

   hba_byte_buffer #(.DEPTH(BLK_BYTES)) u_buf (
      .clk(clk), .rst_n(rst_n), .clr(tail_valid), .load(rs_fire),
      .load_fill({1'b0, rs_count[BLK_LG-1:0]}), .load_data(rs_buf),
      .push(push), .push_byte(in_data), .pop(pop),
      .fill(fill), .data(buf_data));

   always_comb begin
      rs_fire   = rs_valid & ~busy;
      cmd_ready = ~busy & ~rs_valid;
      cmd_fire  = cmd_valid & cmd_ready;
      cmd_err   = cmd_fire & ovf;
      start     = cmd_fire & ~ovf & (cmd_final | (cmd_len != '0));
      in_ready  = busy & (rem_q != '0) & (fill < FILL_W'(BLK_BYTES));
      out_valid = busy & (quota_q != '0) & (fill >= FILL_W'(WB)) & avail;
      push      = in_valid & in_ready;
      pop       = out_valid & out_ready;
      done      = busy & (rem_q == '0) & (quota_q == '0);
      tail_valid  = done & (kind_q == HBA_FINAL);
      tail_nbytes = fill[1:0];
      tail_total  = proc_cnt + CNT_W'(fill);
      ctx_count   = proc_cnt + CNT_W'(fill);
      ctx_buf     = buf_data;
      out_data    = buf_data[31:0];
   end

   for (genvar b = 0; b < WB - 1; b++) begin : g_tail_lane
      assign tail_data[b*8 +: 8] = (fill > FILL_W'(b)) ? buf_data[b*8 +: 8] : 8'h00;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         rem_q   <= '0;
         quota_q <= '0;
         kind_q  <= HBA_UPDATE;
      end else if (start) begin
         busy    <= 1'b1;
         rem_q   <= cmd_len;
         quota_q <= quota_c;
         kind_q  <= hba_kind_e'(cmd_final);
      end else begin
         if (done) busy <= 1'b0;
         if (push) rem_q <= rem_q - 1'b1;
         if (pop)  quota_q <= quota_q - LEN_W'(WB);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          proc_cnt <= '0;
      else if (rs_fire)    proc_cnt <= {rs_count[CNT_W-1:BLK_LG], {BLK_LG{1'b0}}};
      else if (tail_valid) proc_cnt <= '0;
      else if (pop)        proc_cnt <= proc_cnt + CNT_W'(WB);
   end

   // R10
   in_handshake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> busy);
   // R10
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
   // R3
   tail_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tail_valid |=> (!busy && ctx_count == '0));
   // R6
   err_noeffect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_err |=> (!busy && $stable(ctx_count)));
   // R5
   empty_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_fire && !cmd_final && cmd_len == '0) |=> (!busy && $stable(ctx_count)));
   // R2
   retained_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> fill < FILL_W'(BLK_BYTES));
endmodule

// File: tb/tb_hash_block_aligner.sv
`timescale 1ns/1ps
module tb_hash_block_aligner;
   localparam int BLK = 64;
   localparam int LW  = 32;
   localparam int CW  = 64;
   localparam int SW  = 6;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst_n, cmd_valid, cmd_ready, cmd_final, cmd_err;
   logic [LW-1:0] cmd_len;
   logic in_valid, in_ready, out_valid, out_ready, tail_valid, busy, rs_valid;
   logic [7:0] in_data;
   logic [31:0] out_data;
   logic [SW-1:0] fifo_space;
   logic [23:0] tail_data;
   logic [1:0] tail_nbytes;
   logic [CW-1:0] tail_total, ctx_count, rs_count;
   logic [BLK*8-1:0] ctx_buf, rs_buf;

   hash_block_aligner dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_final(cmd_final), .cmd_len(cmd_len), .cmd_err(cmd_err),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .fifo_space(fifo_space), .tail_valid(tail_valid), .tail_data(tail_data),
      .tail_nbytes(tail_nbytes), .tail_total(tail_total), .busy(busy),
      .ctx_count(ctx_count), .ctx_buf(ctx_buf), .rs_valid(rs_valid),
      .rs_count(rs_count), .rs_buf(rs_buf));

   int n_chk = 0;
   int n_fail = 0;
   int serial = 0;
   int ret = 0;
   logic [CW-1:0] cnt = '0;
   logic [7:0] retb [0:63];
   logic [7:0] stream [0:1023];

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] gen(input int s);
      return 8'((s * 37 + 11) ^ (s >> 3));
   endfunction

   task automatic check_ctx(input string req);
      bit ok = 1'b1;
      chk(ctx_count == cnt + CW'(ret), req, "ctx_count", ctx_count, cnt + CW'(ret));
      for (int i = 0; i < ret; i++)
         if (ctx_buf[i*8 +: 8] !== retb[i]) ok = 1'b0;
      chk(ok, "R8", "ctx_buf retained bytes", 64'(ctx_buf[63:0]), 64'(ret));
   endtask

   task automatic run_req(input bit fin, input int len, input int rdy_mode);
      int sum, q, nb, sent, words, tails, stall, cyc;
      logic [23:0] exp_t;
      string rq;
      for (int i = 0; i < ret; i++) stream[i] = retb[i];
      for (int i = 0; i < len; i++) stream[ret + i] = gen(serial + i);
      sum = ret + len;
      q   = fin ? (sum & ~3) : (sum & ~63);
      nb  = sum - q;
      rq  = fin ? "R3" : ((q == 0) ? "R1" : "R2");
      @(negedge clk);
      cmd_valid = 1'b1; cmd_final = fin; cmd_len = LW'(len);
      #1;
      chk(cmd_ready && !cmd_err, "R10", "cmd accepted", {cmd_ready, cmd_err}, 2'b10);
      @(negedge clk);
      cmd_valid = 1'b0;
      #1;
      if (!fin && len == 0) chk(!busy, "R5", "busy after empty update", busy, 0);
      else chk(busy, "R10", "busy after accept", busy, 1);
      sent = 0; words = 0; tails = 0; stall = 0; cyc = 0;
      while (busy && cyc < 20000) begin
         in_valid  = (sent < len);
         in_data   = gen(serial + sent);
         out_ready = (rdy_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
         #1;
         if (out_valid && out_ready) begin
            logic [31:0] ew;
            ew = {stream[4*words+3], stream[4*words+2], stream[4*words+1], stream[4*words]};
            if (out_data !== ew) chk(1'b0, "R4", "word data", out_data, ew);
            words++;
         end
         if (in_valid && in_ready) sent++;
         if (tail_valid) begin
            exp_t = '0;
            for (int k = 0; k < nb; k++) exp_t[k*8 +: 8] = stream[q + k];
            chk(tail_nbytes == 2'(nb), "R3", "tail_nbytes", tail_nbytes, nb);
            chk(tail_data == exp_t, "R3", "tail_data", tail_data, exp_t);
            chk(tail_total == cnt + CW'(sum), "R3", "tail_total", tail_total, cnt + CW'(sum));
            tails++;
         end
         if (fifo_space == '0 && !out_valid && sent == len) stall++;
         if (stall == 20) begin
            chk(words == 32, "R7", "words before credit refresh", words, 32);
            fifo_space = SW'(3);
            stall++;
         end
         @(negedge clk);
         cyc++;
      end
      in_valid = 1'b0;
      #1;
      chk(!busy, "R10", "request completes", busy, 0);
      chk(words == q / 4, rq, "forwarded words", words, q / 4);
      chk(tails == (fin ? 1 : 0), "R3", "tail pulses", tails, fin ? 1 : 0);
      serial += len;
      if (fin) begin
         cnt = '0; ret = 0;
      end else begin
         cnt = cnt + CW'(q);
         ret = nb;
         for (int i = 0; i < ret; i++) retb[i] = stream[q + i];
      end
      check_ctx(fin ? "R3" : "R8");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      n_chk++;
      $display("FAIL R10 watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      rst_n = 1'b0; cmd_valid = 1'b0; cmd_final = 1'b0; cmd_len = '0;
      in_valid = 1'b0; in_data = '0; out_ready = 1'b0; fifo_space = SW'(7);
      rs_valid = 1'b0; rs_count = '0; rs_buf = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R11 reset state
      chk(!busy && !out_valid && !tail_valid, "R11", "idle outputs",
          {busy, out_valid, tail_valid}, 0);
      chk(ctx_count == '0, "R11", "ctx_count", ctx_count, 0);
      chk(cmd_ready, "R11", "cmd_ready", cmd_ready, 1);

      // R6 overflow with retained bytes present
      run_req(1'b0, 10, 0);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_final = 1'b0; cmd_len = 32'hFFFF_FFFF - 32'(ret - 1);
      #1;
      chk(cmd_err, "R6", "cmd_err on overflow", cmd_err, 1);
      @(negedge clk);
      cmd_valid = 1'b0;
      #1;
      chk(!busy, "R6", "no busy after reject", busy, 0);
      check_ctx("R6");
      // R5 empty update with retained bytes
      run_req(1'b0, 0, 0);
      run_req(1'b1, 3, 0);

      for (int a = 0; a < 64; a++) begin
         run_req(1'b0, a, a % 2);
         run_req(1'b0, (a * 13) % 130, (a + 1) % 2);
         if (a % 8 == 3) run_req(1'b0, 0, 0);
         run_req(1'b1, a % 9, a % 2);
      end

      run_req(1'b0, 200, 1);
      run_req(1'b1, 0, 0);

      // R7 credit starvation
      fifo_space = '0;
      run_req(1'b1, 160, 0);
      fifo_space = SW'(7);

      // R9 restore with simultaneous command
      @(negedge clk);
      rs_valid = 1'b1;
      rs_count = 64'h0123_4567_89AB_CD45;
      for (int i = 0; i < BLK; i++) rs_buf[i*8 +: 8] = gen(1000 + i);
      cmd_valid = 1'b1; cmd_final = 1'b0; cmd_len = 32'd5;
      #1;
      chk(!cmd_ready, "R9", "cmd_ready during restore", cmd_ready, 0);
      @(negedge clk);
      rs_valid = 1'b0; cmd_valid = 1'b0;
      #1;
      chk(!busy, "R9", "idle after restore", busy, 0);
      cnt = 64'h0123_4567_89AB_CD40;
      ret = 5;
      for (int i = 0; i < 5; i++) retb[i] = gen(1000 + i);
      check_ctx("R9");
      run_req(1'b1, 0, 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule